// File: doc/BRIEF.md
# Erased Sector Screen

This block is placed after an ECC decoder that has given up on a sector. It decides whether that sector is really an erased page with a few stray bits that read as zero, or a genuinely corrupted programmed sector. The sector's data bytes and its stored check bytes are streamed through a single byte port, and a flag on each byte says which region it belongs to. A programmed bit reads as 0, so for each byte the block counts the zero bits and adds them to a separate total for each region. Once a region's total has passed the limit, further bytes no longer change it.

On the byte flagged as last, the block closes the sector. One cycle later it gives a single-cycle verdict. The sector is either erased, meaning the two totals together are within the limit, or uncorrectable. The verdict also carries the data-region zero count, which a caller reports as the number of corrected bits. When an erased sector has at least one zero in its data, the block raises a request for the data buffer to be rewritten as all ones. The rewrite itself is done outside this block.

With default parameters a sector is 512 data bytes and 13 check bytes, and the limit is 8. The block does not count bytes, so the region sizes are set only by what the feeder sends.

Top module: `erased_sector_screen`

## Requirements
- R1: On each cycle with `byte_vld_i` high, the byte's zero-bit count (BYTE_W minus its population count) is added to a region total. A byte presented with `byte_vld_i` low changes nothing.
- R2: A byte with `is_ecc_i` = 1 is counted only in the check-byte total. A byte with `is_ecc_i` = 0 is counted only in the data total.
- R3: A region total that is at or below LIMIT (8) takes the whole count of the next byte. Once a total exceeds LIMIT it holds its value, so it never exceeds LIMIT + BYTE_W (16).
- R4: With the verdict, `erased_o` is 1 exactly when the data total plus the check-byte total, both including the last byte, is at most LIMIT.
- R5: With the verdict, `uncorrectable_o` is 1 exactly when that sum exceeds LIMIT. Exactly one of `erased_o` and `uncorrectable_o` is high whenever `done_o` is high.
- R6: With the verdict, `fill_ones_o` is 1 exactly when `erased_o` is 1 and the data total is nonzero.
- R7: With the verdict, `data_zeros_o` equals the data total including the last byte, as limited by R3.
- R8: `done_o` is high for exactly one cycle: the cycle after a byte with `byte_vld_i` and `last_i` both high is accepted. When `done_o` is low, `erased_o`, `uncorrectable_o`, `fill_ones_o` and `data_zeros_o` are all 0.
- R9: `start_i` clears both totals. A valid byte presented in the same cycle as `start_i` is counted as the first byte of the new sector.
- R10: After a last byte is accepted, both totals restart from zero, so a sector that follows with no idle cycle is judged on its own bytes.
- R11: During and right after reset, `done_o` and all verdict outputs are 0, and both totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears both totals (begins a sector) |
| byte_vld_i | input | 1 | Byte on `byte_i` is accepted this cycle |
| byte_i | input | BYTE_W | Byte read from the flash |
| is_ecc_i | input | 1 | 1: byte belongs to the check-byte region, 0: data region |
| last_i | input | 1 | Accepted byte closes the sector |
| done_o | output | 1 | Single-cycle verdict strobe |
| erased_o | output | 1 | Sector counts as erased |
| uncorrectable_o | output | 1 | Sector is a real uncorrectable error |
| fill_ones_o | output | 1 | Data buffer must be rewritten to all ones |
| data_zeros_o | output | CNT_W | Data-region zero total (5 bits by default) |

## Verification
The hardest case to reach is a total that has already passed the limit and must then ignore a later byte full of zeros. A plain sum would give the same verdict but a different `data_zeros_o`. The stimulus therefore places a fully zero byte early in the data region, adds a single zero bit soon after to push the total just past 8, and follows with more zero-heavy bytes that must leave the reported count at 9. It also uses a sector of all-zero bytes, whose count must stop at 16. A second hard case is bytes hidden in idle cycles. Sectors are replayed with all-zero bytes placed on cycles where `byte_vld_i` is low. The bench also sends an aborted partial sector followed by `start_i` in the same cycle as a valid byte, and sends sectors back to back with no gap between them.

// File: rtl/erased_pkg.sv
package erased_pkg;

   // width needed to hold a saturated total: up to limit + one full byte
   function automatic int total_width(input int limit, input int byte_w);
      return $clog2(limit + byte_w + 1);
   endfunction

   // width needed to hold the zero count of one byte
   function automatic int byte_count_width(input int byte_w);
      return $clog2(byte_w + 1);
   endfunction

endpackage

// File: rtl/zero_bit_count.sv
module zero_bit_count #(
   parameter int W     = 8,
   parameter int OUT_W = 4
) (
   input  logic [W-1:0]     word_i,
   output logic [OUT_W-1:0] zeros_o
);

   if (OUT_W < 2 || (1 << OUT_W) <= W) begin : g_bad_width
      $error("zero_bit_count: OUT_W too narrow for W");
   end

   always_comb begin
      zeros_o = '0;
      for (int i = 0; i < W; i++) begin
         zeros_o = zeros_o + {{(OUT_W-1){1'b0}}, ~word_i[i]};
      end
   end

endmodule

// File: rtl/sat_total.sv
module sat_total #(
   parameter int CNT_W = 5,
   parameter int INC_W = 4,
   parameter int LIMIT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             add_i,
   input  logic [INC_W-1:0] inc_i,
   input  logic             flush_i,
   output logic [CNT_W-1:0] total_q_o,
   output logic [CNT_W-1:0] total_nx_o
);

   localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

   if (CNT_W <= INC_W) begin : g_bad_width
      $error("sat_total: CNT_W must exceed INC_W");
   end

   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] base;

   always_comb begin
      base = clr_i ? '0 : total_q;
      if (add_i && base <= LIM)
         total_nx_o = base + {{(CNT_W-INC_W){1'b0}}, inc_i};
      else
         total_nx_o = base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       total_q <= '0;
      else if (flush_i) total_q <= '0;
      else              total_q <= total_nx_o;
   end

   assign total_q_o = total_q;

   // R3: a total above the limit holds when neither clear nor flush acts
   a_r3_hold_above_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !flush_i && total_q > LIM) |=> $stable(total_q));

   // R10: flush leaves the total at zero
   a_r10_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (total_q == '0));

   // R9: a clear without a byte leaves the total at zero
   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !add_i) |=> (total_q == '0));

endmodule

// File: rtl/erased_sector_screen.sv
module erased_sector_screen
   import erased_pkg::*;
#(
   parameter  int BYTE_W = 8,
   parameter  int LIMIT  = 8,
   localparam int CNT_W  = total_width(LIMIT, BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              is_ecc_i,
   input  logic              last_i,
   output logic              done_o,
   output logic              erased_o,
   output logic              uncorrectable_o,
   output logic              fill_ones_o,
   output logic [CNT_W-1:0]  data_zeros_o
);

   localparam int INC_W   = byte_count_width(BYTE_W);
   localparam int REGIONS = 2;   // index 0: data, 1: check bytes
   localparam logic [CNT_W:0] LIM_SUM = (CNT_W+1)'(LIMIT);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("erased_sector_screen: BYTE_W must be at least 2");
   end
   if (LIMIT < 1) begin : g_bad_limit
      $error("erased_sector_screen: LIMIT must be at least 1");
   end

   logic [INC_W-1:0] byte_zeros;
   logic             close_sector;
   logic [CNT_W-1:0] total_q  [REGIONS];
   logic [CNT_W-1:0] total_nx [REGIONS];

   zero_bit_count #(.W(BYTE_W), .OUT_W(INC_W)) u_zeros (
      .word_i  (byte_i),
      .zeros_o (byte_zeros)
   );

   assign close_sector = byte_vld_i && last_i;

   for (genvar r = 0; r < REGIONS; r++) begin : g_region
      logic add_en;
      assign add_en = byte_vld_i && ((r == 1) ? is_ecc_i : !is_ecc_i);

      sat_total #(.CNT_W(CNT_W), .INC_W(INC_W), .LIMIT(LIMIT)) u_total (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr_i      (start_i),
         .add_i      (add_en),
         .inc_i      (byte_zeros),
         .flush_i    (close_sector),
         .total_q_o  (total_q[r]),
         .total_nx_o (total_nx[r])
      );
   end

   logic [CNT_W:0] sum_nx;
   logic           erased_nx;
   assign sum_nx    = {1'b0, total_nx[0]} + {1'b0, total_nx[1]};
   assign erased_nx = (sum_nx <= LIM_SUM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o          <= 1'b0;
         erased_o        <= 1'b0;
         uncorrectable_o <= 1'b0;
         fill_ones_o     <= 1'b0;
         data_zeros_o    <= '0;
      end else begin
         done_o          <= close_sector;
         erased_o        <= close_sector && erased_nx;
         uncorrectable_o <= close_sector && !erased_nx;
         fill_ones_o     <= close_sector && erased_nx && (total_nx[0] != '0);
         data_zeros_o    <= close_sector ? total_nx[0] : '0;
      end
   end

   // R5: exactly one verdict with the strobe
   a_r5_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (erased_o != uncorrectable_o));

   // R6: fill request only for an erased sector with data zeros
   a_r6_fill_needs_zeros: assert property (@(posedge clk) disable iff (!rst_n)
      fill_ones_o |-> (erased_o && data_zeros_o != '0));

   // R8: strobe follows an accepted last byte
   a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
      close_sector |=> done_o);

   // R8: outputs quiet without the strobe
   a_r8_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (!erased_o && !uncorrectable_o && !fill_ones_o && data_zeros_o == '0));

   // R3: reported data total bounded by limit plus one byte
   a_r3_bounded_report: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (data_zeros_o <= CNT_W'(LIMIT + BYTE_W)));

endmodule

// File: tb/erased_sector_screen_bench.sv
module erased_sector_screen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_LEN   = 512;
   localparam int ECC_LEN    = 13;
   localparam int LIM        = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_i = 8'h00;
   logic       is_ecc_i = 1'b0;
   logic       last_i = 1'b0;
   logic       done_o, erased_o, uncorrectable_o, fill_ones_o;
   logic [4:0] data_zeros_o;

   erased_sector_screen u_erased_sector_screen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
      .byte_i(byte_i), .is_ecc_i(is_ecc_i), .last_i(last_i), .done_o(done_o),
      .erased_o(erased_o), .uncorrectable_o(uncorrectable_o),
      .fill_ones_o(fill_ones_o), .data_zeros_o(data_zeros_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      bit     er;
      bit     un;
      bit     fi;
      int     dz;
      longint due;
   } verdict_t;

   verdict_t exp_q[$];
   int checks = 0;
   int errors = 0;
   longint cyc = 0;
   int md = 0;
   int me = 0;
   bit finished = 1'b0;
   logic [7:0] dbuf [DATA_LEN];
   logic [7:0] ebuf [ECC_LEN];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
      end
   endtask

   // drive one cycle; the reference totals are updated from the requirements
   task automatic drive(input bit vld, input logic [7:0] b, input bit ecc,
                        input bit last, input bit st);
      @(posedge clk); #1;
      start_i = st; byte_vld_i = vld; byte_i = b; is_ecc_i = ecc; last_i = last;
      if (st) begin md = 0; me = 0; end           // R9
      if (vld) begin
         int z;
         z = 8 - $countones(b);                   // R1
         if (ecc) begin if (me <= LIM) me += z; end   // R2, R3
         else     begin if (md <= LIM) md += z; end
         if (last) begin
            verdict_t v;
            v.er = (md + me) <= LIM;              // R4
            v.un = !v.er;                         // R5
            v.fi = v.er && md != 0;               // R6
            v.dz = md;                            // R7
            v.due = cyc + 1;                      // R8
            exp_q.push_back(v);
            md = 0; me = 0;                       // R10
         end
      end
   endtask

   task automatic idle();
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic fill_clean();
      for (int i = 0; i < DATA_LEN; i++) dbuf[i] = 8'hFF;
      for (int i = 0; i < ECC_LEN; i++)  ebuf[i] = 8'hFF;
   endtask

   // gap>0 inserts an invalid all-zero byte after every gap bytes
   task automatic send_sector(input int gap, input bit start_first, input bit ecc_first);
      int total;
      total = DATA_LEN + ECC_LEN;
      for (int k = 0; k < total; k++) begin
         bit ecc;
         int idx;
         logic [7:0] b;
         if (ecc_first) begin ecc = (k < ECC_LEN); idx = ecc ? k : k - ECC_LEN; end
         else begin ecc = (k >= DATA_LEN); idx = ecc ? k - DATA_LEN : k; end
         b = ecc ? ebuf[idx] : dbuf[idx];
         drive(1'b1, b, ecc, k == total - 1, start_first && k == 0);
         if (gap > 0 && (k % gap) == gap - 1 && k != total - 1)
            drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);  // R1: ignored byte
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (done_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8 unexpected strobe", 1, 0);
            end else begin
               verdict_t v;
               v = exp_q.pop_front();
               check(cyc == v.due, "R8 strobe cycle", int'(cyc), int'(v.due));
               check(erased_o == v.er, "R4 erased", erased_o, v.er);
               check(uncorrectable_o == v.un, "R5 uncorrectable", uncorrectable_o, v.un);
               check(fill_ones_o == v.fi, "R6 fill ones", fill_ones_o, v.fi);
               check(int'(data_zeros_o) == v.dz, "R7 R3 data zeros", data_zeros_o, v.dz);
            end
         end else begin
            check(!erased_o && !uncorrectable_o && !fill_ones_o && data_zeros_o == 0,
                  "R8 quiet outputs", {erased_o, uncorrectable_o, fill_ones_o}, 0);
            if (exp_q.size() != 0 && cyc > exp_q[0].due)
               check(1'b0, "R8 missing strobe", 0, 1);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state
      check(done_o == 0 && erased_o == 0 && uncorrectable_o == 0 && fill_ones_o == 0
            && data_zeros_o == 0, "R11 reset outputs", done_o, 0);
      rst_n = 1'b1;
      idle();

      // all ones: erased, no fill
      fill_clean();
      send_sector(0, 1'b1, 1'b0); idle(); idle();

      // 3 data zeros + 5 check zeros = 8: erased, fill (R4, R6)
      fill_clean(); dbuf[0] = 8'hFE; dbuf[100] = 8'hF3; ebuf[5] = 8'h07;
      send_sector(0, 1'b1, 1'b0); idle();

      // check region 9 zeros, data clean: uncorrectable, dz 0 (R2, R5)
      fill_clean(); ebuf[0] = 8'h00; ebuf[12] = 8'h7F;
      send_sector(0, 1'b1, 1'b0); idle();

      // all-zero data: total stops at 16 (R3)
      for (int i = 0; i < DATA_LEN; i++) dbuf[i] = 8'h00;
      for (int i = 0; i < ECC_LEN; i++) ebuf[i] = 8'hFF;
      send_sector(0, 1'b1, 1'b0); idle();

      // exactly 8 data zeros: erased with fill (R4 boundary)
      fill_clean(); dbuf[7] = 8'h00;
      send_sector(0, 1'b1, 1'b0); idle();

      // 8 then 1 passes the limit, later zeros ignored: dz 9 (R3)
      fill_clean(); dbuf[3] = 8'h00; dbuf[400] = 8'hFE; dbuf[500] = 8'h00; dbuf[511] = 8'h00;
      send_sector(0, 1'b1, 1'b0); idle();

      // gaps carrying zero bytes with valid low (R1)
      fill_clean(); dbuf[0] = 8'hFE; dbuf[100] = 8'hF3; ebuf[5] = 8'h07;
      send_sector(3, 1'b1, 1'b0); idle();

      // aborted partial sector, then start together with first byte (R9)
      for (int i = 0; i < 20; i++) drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
      fill_clean(); dbuf[1] = 8'hBF;
      send_sector(0, 1'b1, 1'b0); idle();

      // start alone, then check bytes first in the stream (R2, R9)
      for (int i = 0; i < 5; i++) drive(1'b1, 8'h0F, 1'b1, 1'b0, 1'b0);
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      fill_clean(); ebuf[2] = 8'h3F; dbuf[9] = 8'hEF;
      send_sector(0, 1'b0, 1'b1); idle();

      // back-to-back sectors with no start and no idle (R10)
      fill_clean(); dbuf[0] = 8'h00; dbuf[1] = 8'h00;
      send_sector(0, 1'b0, 1'b0);
      fill_clean(); dbuf[50] = 8'hFC;
      send_sector(0, 1'b0, 1'b0);
      idle(); idle(); idle();

      check(exp_q.size() == 0, "R8 all verdicts seen", exp_q.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule